// File: doc/BRIEF.md
# ADPCM Playback Address Controller

This block sequences the playback of 4-bit ADPCM samples stored in a sample RAM addressed by 16 bits. A processor writes two address bytes and a control byte through a small register port. Bits of the control byte load the write pointer, the read pointer and the sample length from the latched address pair. The same write also decides whether playback starts, is retriggered, keeps streaming or stops. The controller hands a nibble fetch engine the current fetch address, the end address and the half-point address. It holds the decoder in reset while it is idle and raises a half-played flag or a fully-played flag.

A rate strobe from the external decoder marks each nibble. Every second strobe moves the fetch address on by one byte. When the fetch address matches the half-point, the half-played flag rises. When it reaches the end address outside DMA mode, playback stops. The decoder itself, the DMA data path and RAM arbitration belong to other blocks.

Top module: `adpcm_play_ctrl`

## Requirements
- R1: The address pair is {byte at select 1, byte at select 0}. Select 2 is the control byte. A control write with bit 1 set loads the write pointer from the pair, sets the write offset to 1 if bit 0 is clear and to 0 if it is set, and clears the written-byte count. Each `ram_wr_i` pulse increments the write pointer and the written count, and the count saturates at 0x10000. A control write in the same cycle takes precedence and the pulse is ignored. After reset the write offset is 1.
- R2: A control write with bit 3 set loads the read pointer from the pair. It sets the read offset to 2 if bit 2 is clear and to 1 if it is set. After reset the read offset is 2.
- R3: A control write with bit 4 set loads the length from the pair. The load order within one write is engine reset, then write pointer, then read pointer, then length.
- R4: A write-pointer load sets the streaming flag if two conditions hold. The new write pointer must be 0x0000, 0x8000 or have its low 13 bits all ones. The read pointer and length still in force must either sum (mod 2^16) to a value whose low 13 bits are all ones, or be 0 and 0x8000.
- R5: A control write raises a play request if any of these holds: bit 6 is set; bit 5 (repeat) is set while idle; bit 6 is clear while streaming with a written count above 0x8000. A request while idle starts playback. It sets fetch = read pointer, end = read pointer + length, half = read pointer + length/2 (mod 2^16), clears the nibble phase and both flags, and releases the decoder. `repeat_o` mirrors bit 5 of the last control write.
- R6: A request while playing changes only the half address. It becomes read pointer + 0x85 when the length is 0x8000 to 0x80FF, and read pointer + length/2 otherwise.
- R7: A control write without a request stops playback. It holds the decoder in reset, clears streaming, repeat and the half-played flag, and sets the fully-played flag whether or not playback was running.
- R8: Only a 0-to-1 change of control bit 7 against the stored control byte resets the engine. The reset clears the pointers, the length and the written count, and stops playback with the fully-played flag set. Writing bit 7 while it is already set does not reset anything.
- R9: While playing, each rate strobe toggles the nibble phase. A strobe that finds the phase at 1 advances the fetch address by one. A strobe in a control-write cycle is ignored.
- R10: When a byte advance finds the fetch address equal to the half address, the half-played flag is set and the fully-played flag is cleared.
- R11: When a byte advance finds the fetch address equal to the end address with `dma_mode_i` low, playback stops: both flags clear, the decoder is held in reset, and streaming and repeat clear. With `dma_mode_i` high, the fully-played flag clears and playback continues.
- R12: Every stop clears control bits 6 and 5 in `ctrl_o` and drives `playing_o` low.
- R13: While streaming with more than 0x8000 bytes written, a control write with bit 6 clear still counts as a play request and does not stop playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 address low, 1 address high, 2 control |
| reg_wdata_i | input | 8 | Register write data |
| ram_wr_i | input | 1 | One sample byte written to RAM |
| rate_tick_i | input | 1 | Decoder nibble rate strobe |
| dma_mode_i | input | 1 | Sample data is fed by DMA |
| ctrl_o | output | 8 | Stored control byte |
| wr_ptr_o | output | 16 | Write pointer |
| rd_ptr_o | output | 16 | Read pointer |
| len_o | output | 16 | Sample length |
| wr_ofs_o | output | 2 | Write buffer offset |
| rd_ofs_o | output | 2 | Read buffer offset |
| written_o | output | 17 | Bytes written since last write-pointer load |
| stream_o | output | 1 | Streaming mode |
| repeat_o | output | 1 | Repeat flag |
| play_addr_o | output | 16 | Current fetch address |
| end_addr_o | output | 16 | End address |
| half_addr_o | output | 16 | Half-point address |
| nibble_o | output | 1 | Nibble phase |
| playing_o | output | 1 | Playback in progress |
| dec_rst_o | output | 1 | Decoder held in reset |
| half_irq_o | output | 1 | Half-played flag |
| full_irq_o | output | 1 | Fully-played flag |

## Verification
The bench targets the length window 0x8000 to 0x80FF on retrigger. A design that ignored it would place the half point at read + 0x4008 instead of read + 0x85. It checks that a streaming session with more than 0x8000 bytes written survives a control write with bit 6 clear, where a wrong design would drop playback. Bit 7 is written while already high to catch a level-sensitive reset that would wipe the pointers. A short sample is played to its end with DMA mode low and high. That exposes an off-by-one in the byte advance, a half flag that fires late, or a DMA session that stops at the end address.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;
  // control byte bit positions
  localparam int CB_WBUF   = 0;
  localparam int CB_WLOAD  = 1;
  localparam int CB_RBUF   = 2;
  localparam int CB_RLOAD  = 3;
  localparam int CB_LLOAD  = 4;
  localparam int CB_REPEAT = 5;
  localparam int CB_PLAY   = 6;
  localparam int CB_RESET  = 7;

  typedef struct packed {
    logic [7:0] ctrl;
    logic       play;
    logic       drst;
    logic       nib;
    logic       strm;
    logic       rep;
    logic       hirq;
    logic       firq;
  } play_flags_t;

  localparam play_flags_t FLAGS_RST = '{ctrl: 8'h00, play: 1'b0, drst: 1'b1,
                                        nib: 1'b0, strm: 1'b0, rep: 1'b0,
                                        hirq: 1'b0, firq: 1'b0};
endpackage

// File: rtl/adpcm_addr_latch.sv
module adpcm_addr_latch #(
  parameter int AW = 16,
  parameter int SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] sel_i,
  input  logic [7:0]    wdata_i,
  output logic [AW-1:0] pair_o
);
  localparam int NB = AW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= 8'h00;
      else if (we_i && (sel_i == SW'(b))) byte_q <= wdata_i;
    end
    assign pair_o[8*b +: 8] = byte_q;
  end
endmodule

// File: rtl/adpcm_ptr_unit.sv
module adpcm_ptr_unit
  import adpcm_pkg::*;
#(
  parameter int AW = 16,
  parameter int SM = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [7:0]    ctrl_i,
  input  logic [AW-1:0] pair_i,
  input  logic          eng_rst_i,
  input  logic          ram_wr_i,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW-1:0] len_o,
  output logic [1:0]    wr_ofs_o,
  output logic [1:0]    rd_ofs_o,
  output logic [AW:0]   written_o,
  output logic [AW-1:0] rd_nxt_o,
  output logic [AW-1:0] len_nxt_o,
  output logic          stream_hit_o,
  output logic          lots_written_o
);
  localparam logic [AW-1:0] HALF_ADDR = {1'b1, {(AW-1){1'b0}}};
  localparam logic [AW:0]   WCNT_MAX  = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0]   WCNT_LOTS = {2'b01, {(AW-1){1'b0}}};

  logic [AW-1:0] wr_q, rd_q, len_q, wr_n, rd_n, len_n;
  logic [1:0]    wofs_q, rofs_q, wofs_n, rofs_n;
  logic [AW:0]   wcnt_q, wcnt_n;
  logic          hit;

  function automatic logic stream_ok(logic [AW-1:0] w, logic [AW-1:0] r, logic [AW-1:0] l);
    logic [AW-1:0] s;
    logic w_ok, r_ok;
    s    = r + l;
    w_ok = (w == '0) || (w == HALF_ADDR) || (&w[SM-1:0]);
    r_ok = (&s[SM-1:0]) || ((r == '0) && (l == HALF_ADDR));
    return w_ok && r_ok;
  endfunction

  always_comb begin
    wr_n = wr_q; rd_n = rd_q; len_n = len_q;
    wofs_n = wofs_q; rofs_n = rofs_q; wcnt_n = wcnt_q;
    hit = 1'b0;
    if (ctrl_we_i) begin
      if (eng_rst_i) begin
        wr_n = '0; rd_n = '0; len_n = '0; wcnt_n = '0;
      end
      if (ctrl_i[CB_WLOAD]) begin
        wr_n   = pair_i;
        wofs_n = ctrl_i[CB_WBUF] ? 2'd0 : 2'd1;
        wcnt_n = '0;
        hit    = stream_ok(pair_i, rd_n, len_n);
      end
      if (ctrl_i[CB_RLOAD]) begin
        rd_n   = pair_i;
        rofs_n = ctrl_i[CB_RBUF] ? 2'd1 : 2'd2;
      end
      if (ctrl_i[CB_LLOAD]) len_n = pair_i;
    end else if (ram_wr_i) begin
      wr_n = wr_q + 1'b1;
      if (wcnt_q != WCNT_MAX) wcnt_n = wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; len_q <= '0;
      wofs_q <= 2'd1; rofs_q <= 2'd2; wcnt_q <= '0;
    end else begin
      wr_q <= wr_n; rd_q <= rd_n; len_q <= len_n;
      wofs_q <= wofs_n; rofs_q <= rofs_n; wcnt_q <= wcnt_n;
    end
  end

  assign wr_ptr_o       = wr_q;
  assign rd_ptr_o       = rd_q;
  assign len_o          = len_q;
  assign wr_ofs_o       = wofs_q;
  assign rd_ofs_o       = rofs_q;
  assign written_o      = wcnt_q;
  assign rd_nxt_o       = rd_n;
  assign len_nxt_o      = len_n;
  assign stream_hit_o   = hit;
  assign lots_written_o = wcnt_n > WCNT_LOTS;
endmodule

// File: rtl/adpcm_play_seq.sv
module adpcm_play_seq
  import adpcm_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [15:0] SPEC_OFS = 16'h0085
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [7:0]    ctrl_i,
  input  logic          stream_hit_i,
  input  logic          lots_written_i,
  input  logic [AW-1:0] rd_nxt_i,
  input  logic [AW-1:0] len_nxt_i,
  input  logic          rate_tick_i,
  input  logic          dma_mode_i,
  output logic          eng_rst_o,
  output logic [7:0]    ctrl_o,
  output logic          stream_o,
  output logic          repeat_o,
  output logic [AW-1:0] play_addr_o,
  output logic [AW-1:0] end_addr_o,
  output logic [AW-1:0] half_addr_o,
  output logic          nibble_o,
  output logic          playing_o,
  output logic          dec_rst_o,
  output logic          half_irq_o,
  output logic          full_irq_o
);
  localparam logic [AW-1:0] SPEC_LO = {1'b1, {(AW-1){1'b0}}};
  localparam logic [AW-1:0] SPEC_HI = SPEC_LO | AW'(8'hFF);

  play_flags_t   f_q, f_n;
  logic [AW-1:0] addr_q, end_q, half_q, addr_n, end_n, half_n;
  logic          req;

  function automatic play_flags_t do_stop(play_flags_t f, logic irq);
    f.play = 1'b0;
    f.drst = 1'b1;
    f.nib  = 1'b0;
    f.ctrl[CB_PLAY]   = 1'b0;
    f.ctrl[CB_REPEAT] = 1'b0;
    f.strm = 1'b0;
    f.rep  = 1'b0;
    f.hirq = 1'b0;
    f.firq = irq;
    return f;
  endfunction

  assign eng_rst_o = ctrl_we_i & ctrl_i[CB_RESET] & ~f_q.ctrl[CB_RESET];

  always_comb begin
    f_n = f_q; addr_n = addr_q; end_n = end_q; half_n = half_q;
    req = 1'b0;
    if (ctrl_we_i) begin
      f_n.ctrl = ctrl_i;
      if (eng_rst_o) f_n = do_stop(f_n, 1'b1);
      if (stream_hit_i) f_n.strm = 1'b1;
      f_n.rep = ctrl_i[CB_REPEAT];
      req = ctrl_i[CB_PLAY]
          | (~f_n.play & ctrl_i[CB_REPEAT])
          | (~ctrl_i[CB_PLAY] & f_n.strm & lots_written_i);
      if (req) begin
        if (!f_n.play) begin
          addr_n   = rd_nxt_i;
          end_n    = rd_nxt_i + len_nxt_i;
          half_n   = rd_nxt_i + (len_nxt_i >> 1);
          f_n.nib  = 1'b0;
          f_n.play = 1'b1;
          f_n.drst = 1'b0;
          f_n.hirq = 1'b0;
          f_n.firq = 1'b0;
        end else if (len_nxt_i >= SPEC_LO && len_nxt_i <= SPEC_HI) begin
          half_n = rd_nxt_i + SPEC_OFS[AW-1:0];
        end else begin
          half_n = rd_nxt_i + (len_nxt_i >> 1);
        end
      end else begin
        f_n = do_stop(f_n, 1'b1);
      end
    end else if (f_q.play && rate_tick_i) begin
      if (!f_q.nib) begin
        f_n.nib = 1'b1;
      end else if ((addr_q == end_q) && !dma_mode_i) begin
        f_n = do_stop(f_n, 1'b0);
      end else begin
        f_n.nib = 1'b0;
        if (addr_q == end_q) f_n.firq = 1'b0;
        if (addr_q == half_q) begin
          f_n.hirq = 1'b1;
          f_n.firq = 1'b0;
        end
        addr_n = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q <= FLAGS_RST; addr_q <= '0; end_q <= '0; half_q <= '0;
    end else begin
      f_q <= f_n; addr_q <= addr_n; end_q <= end_n; half_q <= half_n;
    end
  end

  assign ctrl_o      = f_q.ctrl;
  assign stream_o    = f_q.strm;
  assign repeat_o    = f_q.rep;
  assign play_addr_o = addr_q;
  assign end_addr_o  = end_q;
  assign half_addr_o = half_q;
  assign nibble_o    = f_q.nib;
  assign playing_o   = f_q.play;
  assign dec_rst_o   = f_q.drst;
  assign half_irq_o  = f_q.hirq;
  assign full_irq_o  = f_q.firq;
endmodule

// File: rtl/adpcm_play_ctrl.sv
module adpcm_play_ctrl #(
  parameter int          AW       = 16,
  parameter int          SW       = 2,
  parameter int          SM       = 13,
  parameter logic [15:0] SPEC_OFS = 16'h0085
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [SW-1:0] reg_sel_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic          ram_wr_i,
  input  logic          rate_tick_i,
  input  logic          dma_mode_i,
  output logic [7:0]    ctrl_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW-1:0] len_o,
  output logic [1:0]    wr_ofs_o,
  output logic [1:0]    rd_ofs_o,
  output logic [AW:0]   written_o,
  output logic          stream_o,
  output logic          repeat_o,
  output logic [AW-1:0] play_addr_o,
  output logic [AW-1:0] end_addr_o,
  output logic [AW-1:0] half_addr_o,
  output logic          nibble_o,
  output logic          playing_o,
  output logic          dec_rst_o,
  output logic          half_irq_o,
  output logic          full_irq_o
);
  localparam int NB = AW / 8;

  logic [AW-1:0] pair, rd_nxt, len_nxt;
  logic          ctrl_we, eng_rst, stream_hit, lots_written;

  assign ctrl_we = reg_we_i && (reg_sel_i == SW'(NB));

  adpcm_addr_latch #(.AW(AW), .SW(SW)) i_latch (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .pair_o(pair)
  );

  adpcm_ptr_unit #(.AW(AW), .SM(SM)) i_ptr (
    .clk_i, .rst_ni,
    .ctrl_we_i(ctrl_we), .ctrl_i(reg_wdata_i), .pair_i(pair),
    .eng_rst_i(eng_rst), .ram_wr_i,
    .wr_ptr_o, .rd_ptr_o, .len_o, .wr_ofs_o, .rd_ofs_o, .written_o,
    .rd_nxt_o(rd_nxt), .len_nxt_o(len_nxt),
    .stream_hit_o(stream_hit), .lots_written_o(lots_written)
  );

  adpcm_play_seq #(.AW(AW), .SPEC_OFS(SPEC_OFS)) i_seq (
    .clk_i, .rst_ni,
    .ctrl_we_i(ctrl_we), .ctrl_i(reg_wdata_i),
    .stream_hit_i(stream_hit), .lots_written_i(lots_written),
    .rd_nxt_i(rd_nxt), .len_nxt_i(len_nxt),
    .rate_tick_i, .dma_mode_i,
    .eng_rst_o(eng_rst), .ctrl_o, .stream_o, .repeat_o,
    .play_addr_o, .end_addr_o, .half_addr_o, .nibble_o,
    .playing_o, .dec_rst_o, .half_irq_o, .full_irq_o
  );
endmodule

// File: rtl/adpcm_play_ctrl_chk.sv
module adpcm_play_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [7:0]    ctrl_o,
  input logic [AW-1:0] play_addr_o,
  input logic          nibble_o,
  input logic          playing_o,
  input logic          dec_rst_o,
  input logic          half_irq_o,
  input logic          full_irq_o
);
  // R5: a fresh start leaves both flags low
  a_r5_start_clears_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(playing_o) |-> (!half_irq_o && !full_irq_o));

  // R11: decoder reset is the complement of playback
  a_r11_dec_rst_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    playing_o != dec_rst_o);

  // R12: any stop leaves control bits 6 and 5 clear
  a_r12_stop_clears_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(playing_o) |-> (ctrl_o[6:5] == 2'b00));

  // R9: without a register write the fetch address moves by at most one
  a_r9_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(playing_o) && playing_o && !$past(reg_we_i)) |->
      ((play_addr_o == $past(play_addr_o)) || (play_addr_o == $past(play_addr_o) + 1'b1)));

  // R9: nibble phase rests at zero while idle
  a_r9_idle_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !playing_o |-> !nibble_o);

  // R10: the two flags never both high
  a_r10_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(half_irq_o && full_irq_o));
endmodule

bind adpcm_play_ctrl adpcm_play_ctrl_chk #(.AW(AW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .ctrl_o(ctrl_o),
  .play_addr_o(play_addr_o), .nibble_o(nibble_o), .playing_o(playing_o),
  .dec_rst_o(dec_rst_o), .half_irq_o(half_irq_o), .full_irq_o(full_irq_o)
);

// File: tb/test_adpcm_play_ctrl.sv
module test_adpcm_play_ctrl;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, ram_wr_i = 1'b0, rate_tick_i = 1'b0, dma_mode_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic [7:0]  reg_wdata_i = 8'h00;
  logic [7:0]  ctrl_o;
  logic [15:0] wr_ptr_o, rd_ptr_o, len_o, play_addr_o, end_addr_o, half_addr_o;
  logic [1:0]  wr_ofs_o, rd_ofs_o;
  logic [16:0] written_o;
  logic        stream_o, repeat_o, nibble_o, playing_o, dec_rst_o, half_irq_o, full_irq_o;

  int errors = 0, checks = 0;
  logic done = 1'b0;

  always #5ns clk_i = ~clk_i;

  adpcm_play_ctrl i_adpcm_play_ctrl (.*);

  // reference state
  logic [7:0]  m_lo, m_hi, m_ctrl;
  logic [15:0] m_wr, m_rd, m_len, m_addr, m_end, m_half;
  logic [1:0]  m_wofs, m_rofs;
  logic [16:0] m_wcnt;
  logic        m_strm, m_rep, m_nib, m_play, m_drst, m_hirq, m_firq;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_lo = 0; m_hi = 0; m_ctrl = 0; m_wr = 0; m_rd = 0; m_len = 0;
    m_addr = 0; m_end = 0; m_half = 0; m_wofs = 2'd1; m_rofs = 2'd2; m_wcnt = 0;
    m_strm = 0; m_rep = 0; m_nib = 0; m_play = 0; m_drst = 1; m_hirq = 0; m_firq = 0;
  endtask

  task automatic m_stop(input logic irq);
    m_play = 0; m_drst = 1; m_nib = 0; m_ctrl[6:5] = 2'b00;
    m_strm = 0; m_rep = 0; m_hirq = 0; m_firq = irq;
  endtask

  function automatic logic stream_cond(logic [15:0] w, logic [15:0] r, logic [15:0] l);
    logic [15:0] s = r + l;
    return ((w == 16'h0000) || (w == 16'h8000) || (w[12:0] == 13'h1fff)) &&
           ((s[12:0] == 13'h1fff) || ((r == 0) && (l == 16'h8000)));
  endfunction

  task automatic m_step();
    logic [7:0] d;
    logic req;
    logic ctrl_wr;
    d = reg_wdata_i;
    ctrl_wr = reg_we_i && reg_sel_i == 2'd2;
    if (reg_we_i && reg_sel_i == 2'd0) m_lo = d;
    if (reg_we_i && reg_sel_i == 2'd1) m_hi = d;
    if (ctrl_wr) begin
      logic rise = d[7] && !m_ctrl[7];
      m_ctrl = d;
      if (rise) begin
        m_wr = 0; m_rd = 0; m_len = 0; m_wcnt = 0;
        m_stop(1'b1);
      end
      if (d[1]) begin
        m_wr = {m_hi, m_lo}; m_wofs = d[0] ? 2'd0 : 2'd1; m_wcnt = 0;
        if (stream_cond(m_wr, m_rd, m_len)) m_strm = 1;
      end
      if (d[3]) begin m_rd = {m_hi, m_lo}; m_rofs = d[2] ? 2'd1 : 2'd2; end
      if (d[4]) m_len = {m_hi, m_lo};
      m_rep = d[5];
      req = d[6] || (!m_play && d[5]) || (!d[6] && m_strm && (m_wcnt > 17'h8000));
      if (req && !m_play) begin
        m_addr = m_rd; m_end = m_rd + m_len; m_half = m_rd + (m_len >> 1);
        m_nib = 0; m_play = 1; m_drst = 0; m_hirq = 0; m_firq = 0;
      end else if (req) begin
        if (m_len >= 16'h8000 && m_len <= 16'h80ff) m_half = m_rd + 16'h0085;
        else m_half = m_rd + (m_len >> 1);
      end else m_stop(1'b1);
    end else begin
      if (ram_wr_i) begin
        m_wr = m_wr + 1;
        if (m_wcnt != 17'h10000) m_wcnt = m_wcnt + 1;
      end
      if (m_play && rate_tick_i) begin
        if (!m_nib) m_nib = 1;
        else if (m_addr == m_end && !dma_mode_i) m_stop(1'b0);
        else begin
          m_nib = 0;
          if (m_addr == m_end) m_firq = 0;
          if (m_addr == m_half) begin m_hirq = 1; m_firq = 0; end
          m_addr = m_addr + 1;
        end
      end
    end
  endtask

  task automatic compare_all();
    chk("R1 wr_ptr", 32'(wr_ptr_o), 32'(m_wr));
    chk("R1 wr_ofs", 32'(wr_ofs_o), 32'(m_wofs));
    chk("R1 written", 32'(written_o), 32'(m_wcnt));
    chk("R2 rd_ptr", 32'(rd_ptr_o), 32'(m_rd));
    chk("R2 rd_ofs", 32'(rd_ofs_o), 32'(m_rofs));
    chk("R3 len", 32'(len_o), 32'(m_len));
    chk("R4 stream", 32'(stream_o), 32'(m_strm));
    chk("R5 repeat", 32'(repeat_o), 32'(m_rep));
    chk("R5 end", 32'(end_addr_o), 32'(m_end));
    chk("R6 half", 32'(half_addr_o), 32'(m_half));
    chk("R9 play_addr", 32'(play_addr_o), 32'(m_addr));
    chk("R9 nibble", 32'(nibble_o), 32'(m_nib));
    chk("R7 playing", 32'(playing_o), 32'(m_play));
    chk("R11 dec_rst", 32'(dec_rst_o), 32'(m_drst));
    chk("R10 half_irq", 32'(half_irq_o), 32'(m_hirq));
    chk("R7 full_irq", 32'(full_irq_o), 32'(m_firq));
    chk("R12 ctrl", 32'(ctrl_o), 32'(m_ctrl));
  endtask

  task automatic cycle();
    @(posedge clk_i);
    m_step();
    #1ns;
    compare_all();
  endtask

  task automatic drive(input logic we, input logic [1:0] sel, input logic [7:0] d,
                       input logic ram, input logic tick);
    reg_we_i = we; reg_sel_i = sel; reg_wdata_i = d; ram_wr_i = ram; rate_tick_i = tick;
    cycle();
    reg_we_i = 0; ram_wr_i = 0; rate_tick_i = 0;
  endtask

  task automatic set_pair(input logic [15:0] a);
    drive(1, 2'd0, a[7:0], 0, 0);
    drive(1, 2'd1, a[15:8], 0, 0);
  endtask

  task automatic ctrl(input logic [7:0] d);
    drive(1, 2'd2, d, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(0, 2'd0, 8'h00, 0, 1);
  endtask

  initial begin
    #1_500_000ns;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_reset();
    repeat (3) @(posedge clk_i);
    #2ns rst_ni = 1'b1;
    #1ns compare_all();  // reset state for every output

    // R1 R2 R3 loads and offsets
    set_pair(16'h1000); ctrl(8'h0C);
    chk("R2 rd loaded", 32'(rd_ptr_o), 32'h1000);
    chk("R2 rd offset bit2 set", 32'(rd_ofs_o), 32'd1);
    set_pair(16'h0FFF); ctrl(8'h10);
    chk("R3 len loaded", 32'(len_o), 32'h0FFF);
    // R4 stream, with play so it survives the write
    set_pair(16'h8000); ctrl(8'h42);
    chk("R4 stream set", 32'(stream_o), 32'd1);
    chk("R1 wr loaded", 32'(wr_ptr_o), 32'h8000);
    chk("R1 wr offset bit0 clear", 32'(wr_ofs_o), 32'd1);
    // R13 fill beyond half of RAM, then bit6 clear keeps playing
    for (int i = 0; i < 32'h8001; i++) drive(0, 2'd0, 8'h00, 1, 0);
    chk("R1 written count", 32'(written_o), 32'h8001);
    ctrl(8'h00);
    chk("R13 stream keeps playing", 32'(playing_o), 32'd1);
    chk("R13 stream flag held", 32'(stream_o), 32'd1);

    // R6 special half window
    ctrl(8'h00);
    ctrl(8'h80); ctrl(8'h00);
    set_pair(16'h2000); ctrl(8'h08);
    set_pair(16'h8010); ctrl(8'h10);
    ctrl(8'h40);
    chk("R5 half on start", 32'(half_addr_o), 32'h6008);
    chk("R5 end on start", 32'(end_addr_o), 32'hA010);
    chk("R5 decoder released", 32'(dec_rst_o), 32'd0);
    ctrl(8'h40);
    chk("R6 special half", 32'(half_addr_o), 32'h2085);
    chk("R6 end unchanged", 32'(end_addr_o), 32'hA010);

    // R8 rising edge reset, then level high ignored
    ctrl(8'h80);
    chk("R8 reset rd", 32'(rd_ptr_o), 32'h0);
    chk("R8 reset stop", 32'(playing_o), 32'd0);
    chk("R8 full flag", 32'(full_irq_o), 32'd1);
    set_pair(16'h0300); ctrl(8'h88);
    chk("R8 held bit7 no reset", 32'(rd_ptr_o), 32'h0300);
    ctrl(8'h00);

    // R9 R10 R11 short sample
    set_pair(16'h0100); ctrl(8'h08);
    set_pair(16'h0004); ctrl(8'h10);
    ctrl(8'h40);
    ticks(1);
    chk("R9 nibble after one tick", 32'(nibble_o), 32'd1);
    chk("R9 addr after one tick", 32'(play_addr_o), 32'h0100);
    ticks(5);
    chk("R10 half flag", 32'(half_irq_o), 32'd1);
    chk("R9 addr after six ticks", 32'(play_addr_o), 32'h0103);
    ticks(4);
    chk("R11 end stop", 32'(playing_o), 32'd0);
    chk("R11 flags clear", 32'({half_irq_o, full_irq_o}), 32'd0);
    chk("R11 decoder reset", 32'(dec_rst_o), 32'd1);
    dma_mode_i = 1'b1;
    ctrl(8'h40);
    ticks(12);
    chk("R11 dma keeps playing", 32'(playing_o), 32'd1);
    chk("R11 dma addr passes end", 32'(play_addr_o), 32'h0106);
    dma_mode_i = 1'b0;

    // R12 stop clears bits 6 and 5; R7 full flag
    ctrl(8'h20);
    chk("R12 ctrl bits cleared", 32'(ctrl_o[6:5]), 32'd0);
    chk("R12 stopped", 32'(playing_o), 32'd0);
    chk("R7 full flag on stop", 32'(full_irq_o), 32'd1);
    ctrl(8'h20);
    chk("R5 repeat starts from idle", 32'(playing_o), 32'd1);
    chk("R5 repeat flag", 32'(repeat_o), 32'd1);

    // random phase, compared every cycle
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom_range(0, 99);
      logic tk = $urandom_range(0, 1) == 1;
      if (($urandom_range(0, 199)) == 0) dma_mode_i = ~dma_mode_i;
      if (r < 6) begin
        logic [7:0] d = 8'($urandom());
        d[7] = ($urandom_range(0, 9) == 0);
        drive(1, 2'd2, d, 0, tk);
      end else if (r < 16) begin
        logic [7:0] hv;
        case ($urandom_range(0, 4))
          0: hv = 8'h00;
          1: hv = 8'h80;
          2: hv = 8'h1F;
          3: hv = 8'h80;
          default: hv = 8'($urandom());
        endcase
        if ($urandom_range(0, 1) == 1) drive(1, 2'd1, hv, 0, tk);
        else drive(1, 2'd0, ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom_range(0, 15)), 0, tk);
      end else if (r < 24) begin
        drive(0, 2'd0, 8'h00, 1, tk);
      end else begin
        drive(0, 2'd0, 8'h00, 0, tk);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule